// File: doc/BRIEF.md
# Camera Serial Receiver Register Block

This block holds the control and status registers of a camera serial receiver. A host reaches it over a plain 32-bit register bus with separate write and read strobes. Reads return data one cycle after the strobe, and a valid flag marks that cycle. Some settings act at once: receiver enable, clock select, output alignment, the differential pair swap and the per-lane PHY enables. Other settings stay in a staging copy until software requests a shadow update: the data format, the lane count, the frame size and the PHY settle time. The active copy the datapath consumes changes only on that request.

Event strobes from the receive datapath set sticky bits in an interrupt source register. Software clears those bits by writing ones. A mask register selects which bits drive the single registered interrupt line. One mask bit covers all four per-lane start-of-transmission error bits. A parameter selects whether frame start and frame end can be unmasked. A soft-reset request clears the source bits and the active configuration. It leaves the mask and the staging registers as they were.

Top module: `cam_rx_regs`

## Requirements
- R1: After reset every register reads 0, the interrupt is low, and all active configuration and control outputs are 0. The status word at offset 0x0C is the exception: it always reads back the `phy_stat` input, and no write affects it.
- R2: Read data appears on `rdata` with `rd_valid` high in the cycle after `rd_en`. Writable fields read back at these positions:
  - offset 0x00: bit 0 enable, bit 8 external wrapper clock, bit 20 32-bit alignment, bit 31 pair swap;
  - offset 0x04: lane enables in bits [4:0], settle time in bits [31:27];
  - offset 0x08: lane count minus one in bits [1:0], data-type code in bits [7:2];
  - offset 0x2C: width in bits [31:16], height in bits [15:0].
  Bits that are not implemented read as 0.
- R3: `rx_enable`, `ext_wclk`, `align32`, `dpdn_swap` and `lane_en` follow the written control and PHY fields from the cycle after the write, with no shadow update.
- R4: Writes to the data type, lane count, width, height and settle fields leave the `act_*` outputs unchanged. A write to offset 0x00 with bit 16 set loads all five fields into the active copy at that edge. Bit 16 always reads back as 0. Offset 0x38 reads the active copy in the same layout as offset 0x08.
- R5: A high bit of `ev_set` at a position in 0xFC00F03F sets the matching source bit at offset 0x14. The bit stays set after the strobe ends. Strobes at any other position are ignored.
- R6: Writing offset 0x14 clears exactly the source bits written as one and leaves the others unchanged.
- R7: A source bit whose event strobe is high in the same cycle as a clearing write stays set.
- R8: The writable mask bits at offset 0x10 are 0xFC00103F when `FRAME_IRQ_EN` is 1 and 0xF000103F when it is 0. Other mask bits read as 0.
- R9: `irq` is the registered OR of the source bits ANDed with the mask. Mask bit 12 enables source bits 15 to 12. `irq` rises in the cycle after a masked source bit is set or unmasked.
- R10: A write to offset 0x00 with bit 4 set has these effects:
  - it clears the source register and the active copy at that edge;
  - it overrides an event strobe or a shadow update in the same cycle;
  - it keeps the mask and the staging fields;
  - bit 4 reads back as 1 only for a read issued in the cycle right after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High in the cycle after rd_en |
| ev_set | input | 32 | Event strobes from the datapath, one per source bit |
| phy_stat | input | 32 | PHY status word shown at offset 0x0C |
| irq | output | 1 | Registered interrupt request |
| rx_enable | output | 1 | Receiver enable |
| ext_wclk | output | 1 | Select the external wrapper clock |
| align32 | output | 1 | 32-bit output alignment (0 is 24-bit) |
| dpdn_swap | output | 1 | Swap the differential pair |
| lane_en | output | LANE_N+1 | Clock lane (bit 0) and data lane enables |
| act_lanes_m1 | output | 2 | Active lane count minus one |
| act_dtype | output | 6 | Active data-type code |
| act_width | output | 16 | Active frame width |
| act_height | output | 16 | Active frame height |
| act_settle | output | 5 | Active PHY settle time |

## Verification
Three pairs of functions can fall in the same cycle:
- an event strobe and a clearing write to the source register;
- a soft reset and an event strobe;
- a soft reset and a shadow update requested in one control write.

The bench provokes each collision by driving the event strobe and the write in a single cycle, or by setting both control bits in one write. It then judges the result by reading the source register, or by watching the active configuration outputs, in the following cycles. The expected outcomes are that the set wins over the clear, and that the soft reset wins over both the event and the update.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;

  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_PHY   = 8'h04;
  localparam logic [7:0] OFS_CFG   = 8'h08;
  localparam logic [7:0] OFS_PSTAT = 8'h0C;
  localparam logic [7:0] OFS_MASK  = 8'h10;
  localparam logic [7:0] OFS_SRC   = 8'h14;
  localparam logic [7:0] OFS_RES   = 8'h2C;
  localparam logic [7:0] OFS_SHCFG = 8'h38;

  localparam int B_EN     = 0;
  localparam int B_SRST   = 4;
  localparam int B_EXTCLK = 8;
  localparam int B_UPD    = 16;
  localparam int B_ALIGN  = 20;
  localparam int B_SWAP   = 31;

  localparam int SETTLE_LSB = 27;
  localparam int SETTLE_W   = 5;
  localparam int DTYPE_W    = 6;
  localparam int DIM_W      = 16;

  localparam logic [31:0] SRC_IMPL = 32'hFC00_F03F;
  localparam int SOT_LSB = 12;
  localparam int SOT_N   = 4;

  typedef struct packed {
    logic swap;
    logic align32;
    logic extclk;
    logic en;
  } ctrl_t;

  // Mask bits software may set, per variant
  function automatic logic [31:0] mask_writable(input bit frame_en);
    logic [31:0] m;
    m = 32'hF000_103F;
    if (frame_en) m = m | 32'h0C00_0000;
    return m;
  endfunction

  // One mask bit fans out over the per-lane SOT error group
  function automatic logic [31:0] expand_mask(input logic [31:0] m);
    logic [31:0] r;
    r = m;
    r[SOT_LSB +: SOT_N] = {SOT_N{m[SOT_LSB]}};
    return r;
  endfunction

  // Format-register image: lanes-1 low, type code above
  function automatic logic [31:0] cfg_image(input logic [1:0] lanes, input logic [DTYPE_W-1:0] dt);
    logic [31:0] r;
    r = '0;
    r[1:0] = lanes;
    r[2 +: DTYPE_W] = dt;
    return r;
  endfunction

endpackage

// File: rtl/crx_cfg_regs.sv
module crx_cfg_regs
  import cam_rx_pkg::*;
#(
  parameter int LANE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wr_ctrl,
  input  logic                wr_phy,
  input  logic                wr_cfg,
  input  logic                wr_res,
  input  logic                srst_pulse,
  input  logic                upd_pulse,
  output ctrl_t               ctrl_q,
  output logic                srst_q,
  output logic [LANE_W-1:0]   lane_q,
  output logic [SETTLE_W-1:0] settle_q,
  output logic [1:0]          lanes_q,
  output logic [DTYPE_W-1:0]  dtype_q,
  output logic [DIM_W-1:0]    width_q,
  output logic [DIM_W-1:0]    height_q,
  output logic [1:0]          act_lanes,
  output logic [DTYPE_W-1:0]  act_dtype,
  output logic [DIM_W-1:0]    act_width,
  output logic [DIM_W-1:0]    act_height,
  output logic [SETTLE_W-1:0] act_settle
);

  // Control bits act immediately
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_pulse;
      if (wr_ctrl) begin
        ctrl_q.en      <= wdata[B_EN];
        ctrl_q.extclk  <= wdata[B_EXTCLK];
        ctrl_q.align32 <= wdata[B_ALIGN];
        ctrl_q.swap    <= wdata[B_SWAP];
      end
    end
  end

  // Staging registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q   <= '0;
      settle_q <= '0;
      lanes_q  <= '0;
      dtype_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
    end else begin
      if (wr_phy) begin
        lane_q   <= wdata[LANE_W-1:0];
        settle_q <= wdata[SETTLE_LSB +: SETTLE_W];
      end
      if (wr_cfg) begin
        lanes_q <= wdata[1:0];
        dtype_q <= wdata[2 +: DTYPE_W];
      end
      if (wr_res) begin
        width_q  <= wdata[31:16];
        height_q <= wdata[15:0];
      end
    end
  end

  // Active copy: soft reset beats the update request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lanes  <= '0;
      act_dtype  <= '0;
      act_width  <= '0;
      act_height <= '0;
      act_settle <= '0;
    end else if (srst_pulse) begin
      act_lanes  <= '0;
      act_dtype  <= '0;
      act_width  <= '0;
      act_height <= '0;
      act_settle <= '0;
    end else if (upd_pulse) begin
      act_lanes  <= lanes_q;
      act_dtype  <= dtype_q;
      act_width  <= width_q;
      act_height <= height_q;
      act_settle <= settle_q;
    end
  end

endmodule

// File: rtl/crx_irq_regs.sv
module crx_irq_regs
  import cam_rx_pkg::*;
#(
  parameter bit FRAME_IRQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_mask,
  input  logic              wr_src,
  input  logic              srst_pulse,
  input  logic [DATA_W-1:0] ev_set,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] src_q,
  output logic              irq_q
);

  localparam logic [DATA_W-1:0] MASK_WR = mask_writable(FRAME_IRQ_EN);

  logic [DATA_W-1:0] mask_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata & MASK_WR;
  end

  // One sticky cell per implemented source bit; set beats clear
  for (genvar i = 0; i < DATA_W; i++) begin : g_src
    if (SRC_IMPL[i]) begin : g_live
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cell_q <= 1'b0;
        else if (srst_pulse)          cell_q <= 1'b0;
        else if (ev_set[i])           cell_q <= 1'b1;
        else if (wr_src && wdata[i])  cell_q <= 1'b0;
      end
      assign src_q[i] = cell_q;
    end else begin : g_tied
      assign src_q[i] = 1'b0;
    end
  end

  assign mask_eff = expand_mask(mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(src_q & mask_eff);
  end

endmodule

// File: rtl/crx_rd_mux.sv
module crx_rd_mux
  import cam_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  ctrl_t               ctrl_q,
  input  logic                srst_q,
  input  logic [LANE_W-1:0]   lane_q,
  input  logic [SETTLE_W-1:0] settle_q,
  input  logic [1:0]          lanes_q,
  input  logic [DTYPE_W-1:0]  dtype_q,
  input  logic [DIM_W-1:0]    width_q,
  input  logic [DIM_W-1:0]    height_q,
  input  logic [1:0]          act_lanes,
  input  logic [DTYPE_W-1:0]  act_dtype,
  input  logic [DATA_W-1:0]   phy_stat,
  input  logic [DATA_W-1:0]   mask_q,
  input  logic [DATA_W-1:0]   src_q,
  output logic [DATA_W-1:0]   rdata,
  output logic                rd_valid
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      sel[B_EN]     = ctrl_q.en;
      sel[B_SRST]   = srst_q;
      sel[B_EXTCLK] = ctrl_q.extclk;
      sel[B_ALIGN]  = ctrl_q.align32;
      sel[B_SWAP]   = ctrl_q.swap;
    end else if (addr == ADDR_W'(OFS_PHY)) begin
      sel[LANE_W-1:0]              = lane_q;
      sel[SETTLE_LSB +: SETTLE_W]  = settle_q;
    end else if (addr == ADDR_W'(OFS_CFG)) begin
      sel = cfg_image(lanes_q, dtype_q);
    end else if (addr == ADDR_W'(OFS_PSTAT)) begin
      sel = phy_stat;
    end else if (addr == ADDR_W'(OFS_MASK)) begin
      sel = mask_q;
    end else if (addr == ADDR_W'(OFS_SRC)) begin
      sel = src_q;
    end else if (addr == ADDR_W'(OFS_RES)) begin
      sel = {width_q, height_q};
    end else if (addr == ADDR_W'(OFS_SHCFG)) begin
      sel = cfg_image(act_lanes, act_dtype);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end

endmodule

// File: rtl/cam_rx_regs.sv
module cam_rx_regs
  import cam_rx_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int LANE_N       = 4,
  parameter bit FRAME_IRQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [31:0]       ev_set,
  input  logic [31:0]       phy_stat,
  output logic              irq,
  output logic              rx_enable,
  output logic              ext_wclk,
  output logic              align32,
  output logic              dpdn_swap,
  output logic [LANE_N:0]   lane_en,
  output logic [1:0]        act_lanes_m1,
  output logic [5:0]        act_dtype,
  output logic [15:0]       act_width,
  output logic [15:0]       act_height,
  output logic [4:0]        act_settle
);

  localparam int LANE_W = LANE_N + 1;

  // Decoded write events, named for the checker
  logic wr_ctrl, wr_phy, wr_cfg, wr_res, wr_mask, wr_src;
  logic srst_pulse, upd_pulse;

  assign wr_ctrl    = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_phy     = wr_en && (addr == ADDR_W'(OFS_PHY));
  assign wr_cfg     = wr_en && (addr == ADDR_W'(OFS_CFG));
  assign wr_res     = wr_en && (addr == ADDR_W'(OFS_RES));
  assign wr_mask    = wr_en && (addr == ADDR_W'(OFS_MASK));
  assign wr_src     = wr_en && (addr == ADDR_W'(OFS_SRC));
  assign srst_pulse = wr_ctrl && wdata[B_SRST];
  assign upd_pulse  = wr_ctrl && wdata[B_UPD];

  ctrl_t               ctrl_q;
  logic                srst_q;
  logic [LANE_W-1:0]   lane_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [1:0]          lanes_q;
  logic [DTYPE_W-1:0]  dtype_q;
  logic [DIM_W-1:0]    width_q, height_q;
  logic [DATA_W-1:0]   mask_q, src_q;
  logic                irq_q;

  crx_cfg_regs #(.LANE_W(LANE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_ctrl(wr_ctrl), .wr_phy(wr_phy), .wr_cfg(wr_cfg), .wr_res(wr_res),
    .srst_pulse(srst_pulse), .upd_pulse(upd_pulse),
    .ctrl_q(ctrl_q), .srst_q(srst_q), .lane_q(lane_q), .settle_q(settle_q),
    .lanes_q(lanes_q), .dtype_q(dtype_q), .width_q(width_q), .height_q(height_q),
    .act_lanes(act_lanes_m1), .act_dtype(act_dtype), .act_width(act_width),
    .act_height(act_height), .act_settle(act_settle)
  );

  crx_irq_regs #(.FRAME_IRQ_EN(FRAME_IRQ_EN)) u_irq (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_mask(wr_mask), .wr_src(wr_src), .srst_pulse(srst_pulse),
    .ev_set(ev_set), .mask_q(mask_q), .src_q(src_q), .irq_q(irq_q)
  );

  crx_rd_mux #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .ctrl_q(ctrl_q), .srst_q(srst_q), .lane_q(lane_q), .settle_q(settle_q),
    .lanes_q(lanes_q), .dtype_q(dtype_q), .width_q(width_q), .height_q(height_q),
    .act_lanes(act_lanes_m1), .act_dtype(act_dtype), .phy_stat(phy_stat),
    .mask_q(mask_q), .src_q(src_q), .rdata(rdata), .rd_valid(rd_valid)
  );

  assign irq       = irq_q;
  assign rx_enable = ctrl_q.en;
  assign ext_wclk  = ctrl_q.extclk;
  assign align32   = ctrl_q.align32;
  assign dpdn_swap = ctrl_q.swap;
  assign lane_en   = lane_q;

endmodule

// File: rtl/cam_rx_regs_chk.sv
module cam_rx_regs_chk
  import cam_rx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        srst_pulse,
  input logic        upd_pulse,
  input logic        srst_q,
  input logic        wr_mask,
  input logic        wr_src,
  input logic [31:0] wdata,
  input logic [31:0] ev_set,
  input logic [31:0] src_q,
  input logic [31:0] mask_q,
  input logic        irq,
  input logic [5:0]  dtype_q,
  input logic [5:0]  act_dtype,
  input logic [15:0] act_width
);

  // R10
  srst_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> (src_q == '0));

  // R10
  srst_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_pulse && !wr_mask) |=> $stable(mask_q));

  // R10
  srst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !srst_pulse) |=> !srst_q);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev_set & SRC_IMPL)) && !srst_pulse) |=>
      ((src_q & $past(ev_set & SRC_IMPL)) == $past(ev_set & SRC_IMPL)));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && !srst_pulse && (ev_set == '0)) |=> ((src_q & $past(wdata)) == '0));

  // R4
  upd_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && !srst_pulse) |=> (act_dtype == $past(dtype_q)));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_pulse && !srst_pulse) |=> $stable(act_width));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(src_q & expand_mask(mask_q)))));

endmodule

bind cam_rx_regs cam_rx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst_pulse(srst_pulse), .upd_pulse(upd_pulse),
  .srst_q(srst_q), .wr_mask(wr_mask), .wr_src(wr_src), .wdata(wdata),
  .ev_set(ev_set), .src_q(src_q), .mask_q(mask_q), .irq(irq),
  .dtype_q(dtype_q), .act_dtype(act_dtype), .act_width(act_width)
);

// File: tb/cam_rx_regs_test.sv
`timescale 1ns/1ps
module cam_rx_regs_test;

  localparam bit FRAME = 1'b1;
  localparam logic [31:0] PSTAT = 32'hA5A5_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, ev_set = '0;
  logic [31:0] phy_stat = PSTAT;
  logic [31:0] rdata;
  logic        rd_valid, irq, rx_enable, ext_wclk, align32, dpdn_swap;
  logic [4:0]  lane_en;
  logic [1:0]  act_lanes_m1;
  logic [5:0]  act_dtype;
  logic [15:0] act_width, act_height;
  logic [4:0]  act_settle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cam_rx_regs #(.ADDR_W(8), .LANE_N(4), .FRAME_IRQ_EN(FRAME)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .ev_set(ev_set),
    .phy_stat(phy_stat), .irq(irq), .rx_enable(rx_enable), .ext_wclk(ext_wclk),
    .align32(align32), .dpdn_swap(dpdn_swap), .lane_en(lane_en),
    .act_lanes_m1(act_lanes_m1), .act_dtype(act_dtype), .act_width(act_width),
    .act_height(act_height), .act_settle(act_settle)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] ev = '0);
    addr = a; wdata = d; ev_set = ev; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_set = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_ev(input logic [31:0] ev);
    ev_set = ev;
    @(negedge clk);
    ev_set = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] bench_mask_wr();
    return FRAME ? 32'hFC00_103F : 32'hF000_103F;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 act_dtype", {26'b0, act_dtype}, 0);
    check("R1 lane_en", {27'b0, lane_en}, 0);
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 phy");
    rd(8'h10, 32'h0, "R1 mask");
    rd(8'h14, 32'h0, "R1 src");
    rd(8'h38, 32'h0, "R1 shadow");
    rd(8'h0C, PSTAT, "R1 phy status");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, PSTAT, "R1 phy status read-only");

    // R2/R3 direct controls
    wr(8'h00, 32'h8010_0101);
    check("R3 rx_enable", {31'b0, rx_enable}, 1);
    check("R3 ext_wclk", {31'b0, ext_wclk}, 1);
    check("R3 align32", {31'b0, align32}, 1);
    check("R3 dpdn_swap", {31'b0, dpdn_swap}, 1);
    rd(8'h00, 32'h8010_0101, "R2 ctrl readback");
    wr(8'h04, 32'h4800_0007);
    check("R3 lane_en", {27'b0, lane_en}, 32'h7);
    rd(8'h04, 32'h4800_0007, "R2 phy readback");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00FF, "R2 cfg unused bits");
    wr(8'h08, (32'h2B << 2) | 32'h1);
    rd(8'h08, 32'h0000_00AD, "R2 cfg readback");
    wr(8'h2C, 32'h0780_0438);
    rd(8'h2C, 32'h0780_0438, "R2 resolution readback");

    // R4 staging does not reach active copy
    check("R4 act_dtype held", {26'b0, act_dtype}, 0);
    check("R4 act_width held", {16'b0, act_width}, 0);
    rd(8'h38, 32'h0, "R4 shadow before update");

    // R4 update
    wr(8'h00, 32'h8011_0101);
    check("R4 act_dtype", {26'b0, act_dtype}, 32'h2B);
    check("R4 act_lanes", {30'b0, act_lanes_m1}, 1);
    check("R4 act_width", {16'b0, act_width}, 32'h780);
    check("R4 act_height", {16'b0, act_height}, 32'h438);
    check("R4 act_settle", {27'b0, act_settle}, 9);
    rd(8'h00, 32'h8010_0101, "R4 update bit reads zero");
    rd(8'h38, 32'h0000_00AD, "R4 shadow readback");
    wr(8'h2C, 32'h0001_0002);
    check("R4 act_width after new staging", {16'b0, act_width}, 32'h780);

    // R8 mask variant
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, bench_mask_wr(), "R8 mask writable bits");
    wr(8'h10, 32'h0);

    // R5 sticky, R9 masked off
    pulse_ev(32'h0000_2000);
    idle(1);
    rd(8'h14, 32'h0000_2000, "R5 sot lane bit sticky");
    check("R9 irq masked", {31'b0, irq}, 0);
    pulse_ev(32'h0010_0000);
    rd(8'h14, 32'h0000_2000, "R5 unimplemented bit ignored");

    // R9 bit 12 enables lane group
    wr(8'h10, 32'h0000_1000);
    idle(1);
    check("R9 irq via sot group", {31'b0, irq}, 1);

    // R6 w1c
    wr(8'h14, 32'h0000_2000);
    idle(1);
    check("R6 irq drops after clear", {31'b0, irq}, 0);
    rd(8'h14, 32'h0, "R6 sot bit cleared");
    pulse_ev(32'h0C00_0021);
    rd(8'h14, 32'h0C00_0021, "R5 frame and error bits");
    wr(8'h14, 32'h0400_0001);
    rd(8'h14, 32'h0800_0020, "R6 partial clear");

    // R7 set and clear in same cycle
    wr(8'h14, 32'h0000_0020, 32'h0000_0020);
    rd(8'h14, 32'h0800_0020, "R7 set wins over clear");
    wr(8'h14, 32'h0800_0000, 32'h0000_0002);
    rd(8'h14, 32'h0000_0022, "R7 clear other bit while set");

    // R9 frame bit unmask path
    wr(8'h10, 32'h0000_0002);
    idle(1);
    check("R9 irq crc unmasked", {31'b0, irq}, 1);

    // R10 soft reset
    wr(8'h00, 32'h8010_0111);
    check("R10 act_dtype cleared", {26'b0, act_dtype}, 0);
    check("R10 act_width cleared", {16'b0, act_width}, 0);
    rd(8'h00, 32'h8010_0111, "R10 reset bit visible once");
    rd(8'h00, 32'h8010_0101, "R10 reset bit self-clears");
    rd(8'h14, 32'h0, "R10 source cleared");
    rd(8'h10, 32'h0000_0002, "R10 mask kept");
    rd(8'h08, 32'h0000_00AD, "R10 staging kept");
    check("R10 irq low", {31'b0, irq}, 0);

    // R10 soft reset beats event in same cycle
    wr(8'h00, 32'h8010_0111, 32'h0000_0002);
    rd(8'h14, 32'h0, "R10 reset beats event");

    // R10 soft reset beats update in same write
    wr(8'h00, 32'h8011_0101);
    check("R4 reload", {26'b0, act_dtype}, 32'h2B);
    wr(8'h00, 32'h8011_0111);
    check("R10 reset beats update", {26'b0, act_dtype}, 0);

    idle(3);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule